// File: doc/BRIEF.md
# DMA Channel Bus-Ownership Arbiter

This block decides which of four DMA channels may use the shared system bus and negotiates bus ownership with the host processor. A channel is a candidate when its request line is high and its mask bit is low. When the first candidate appears, the arbiter raises a hold request toward the processor. It grants nothing until the processor answers with hold-acknowledge. Priority is fixed: channel 0 wins over channel 1, channel 1 over channel 2, and channel 2 over channel 3.

A normal channel receives a one-hot grant toward the transfer engine. The grant lasts until the engine pulses its done input. A channel marked as cascade receives only its own acknowledge line, and it keeps the bus until it lowers its request. At the end of either kind of service, the arbiter checks the other requests again. If one is pending, it passes the bus straight on without releasing hold. It gives the bus back only when nothing is pending. Two arbiters can be chained: the hold request of a second arbiter drives one cascade channel of the first, and that channel's acknowledge drives the second arbiter's hold-acknowledge.

Top module: `dma_bus_arbiter`

## Requirements
- R1: A channel takes part in arbitration only while its request bit is 1 and its mask bit is 0. A masked request never raises hold request and never receives a grant.
- R2: From idle, hold request rises on the clock after a candidate appears. No grant or acknowledge is given until a clock edge at which hold-acknowledge is 1. Hold request stays high whenever any grant or acknowledge is high.
- R3: Channels are compared at the edge where hold-acknowledge is first seen. The lowest-numbered candidate wins; bit 0 is channel 0, the highest priority.
- R4: At most one bit across the grant and cascade-acknowledge outputs is 1 at any time.
- R5: A normal grant ends at the edge where the done input is 1. If any candidate is pending at that edge, the bus passes on the next cycle to the highest-priority candidate, and hold request does not drop.
- R6: If no candidate is pending when service ends, hold request and all grants are 0 on the next cycle.
- R7: A channel whose cascade bit is 1 when it wins receives only its cascade-acknowledge bit. Its grant bit stays 0, and the done input has no effect on it.
- R8: A cascade acknowledge stays high until that channel's request drops. Arbitration then continues as in R5 and R6.
- R9: If hold-acknowledge falls while a channel is served, all grants and acknowledges are 0 on the next clock and hold request is low for that cycle. If a candidate is still pending, the arbiter then requests the bus again.
- R10: While waiting for hold-acknowledge, if every candidate disappears, hold request drops on the next clock and no grant follows.
- R11: During and after synchronous active-low reset, hold request, grant and acknowledge outputs are 0.
- R12: When a second arbiter's hold request drives a cascade channel of this arbiter, and that channel's acknowledge drives the second arbiter's hold-acknowledge, the second arbiter grants its own channels through the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 4 | Per-channel request lines |
| mask_i | input | 4 | Per-channel mask bits, 1 = disabled |
| cascade_i | input | 4 | Per-channel cascade mode bits |
| hold_ack_i | input | 1 | Hold-acknowledge from the processor |
| xfer_done_i | input | 1 | Transfer engine reports the end of the current normal service |
| hold_req_o | output | 1 | Hold request to the processor |
| grant_o | output | 4 | One-hot active channel for the transfer engine |
| cas_ack_o | output | 4 | Acknowledge to the channel served in cascade mode |

## Verification
The bench offers several channels at once, including a masked higher-priority one. A design that ignores the mask, or encodes priority in the wrong direction, would grant the wrong bit. It ends services while requests are still pending and checks that hold request never dips. A design that releases the bus between channels would show a low hold request for one cycle, and one that holds the bus too long would keep hold high after the last service. It pulses done during a cascade grant and removes hold-acknowledge in mid-service. A design that ends cascade service on the done pulse would drop the acknowledge, and one that ignores the loss of acknowledge would leave a grant driven on a bus it no longer owns. A two-arbiter chain shows whether the cascade acknowledge actually reaches a second arbiter as its hold-acknowledge.

// File: rtl/dma_arb_pkg.sv
// Package: shared state type for the DMA bus-ownership arbiter.
// Assumes: nothing beyond standard SystemVerilog.
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,   // bus belongs to the processor, nothing asked
        ARB_WAIT = 2'd1,   // hold raised, waiting for hold-acknowledge
        ARB_OWN  = 2'd2    // a channel is being served
    } arb_state_e;
endpackage

// File: rtl/dma_elig_mask.sv
// Module: forms the per-channel candidate vector from requests and masks.
// Assumes: mask bit 1 disables the channel; purely combinational.
module dma_elig_mask #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] mask_i,
    output logic [NUM_CH-1:0] elig_o
);
    // One gate per channel: request qualified by a clear mask.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign elig_o[c] = req_i[c] & ~mask_i[c];
    end
endmodule

// File: rtl/dma_prio_pick.sv
// Module: fixed-priority selector, the lowest index wins.
// Assumes: combinational; pick_o is one-hot or zero, any_o means a candidate exists.
module dma_prio_pick #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] elig_i,
    output logic [NUM_CH-1:0] pick_o,
    output logic              any_o
);
    logic [NUM_CH:0] blocked;

    assign blocked[0] = 1'b0;
    // Ripple chain: a channel is blocked when any lower index is a candidate.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_prio
        assign pick_o[c]    = elig_i[c] & ~blocked[c];
        assign blocked[c+1] = blocked[c] | elig_i[c];
    end
    assign any_o = blocked[NUM_CH];
endmodule

// File: rtl/dma_arb_fsm.sv
// Module: bus-ownership sequencer. Raises hold, waits for acknowledge,
// serves one channel at a time, and passes the bus on or releases it.
// Assumes: pick_i/elig_any_i come from the priority selector in the same cycle;
// xfer_done_i is meaningful only during a normal grant.
module dma_arb_fsm
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_ack_i,
    input  logic              xfer_done_i,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] cascade_i,
    input  logic [NUM_CH-1:0] pick_i,
    input  logic              elig_any_i,
    output logic              hold_req_o,
    output logic [NUM_CH-1:0] grant_o,
    output logic [NUM_CH-1:0] cas_ack_o
);
    arb_state_e        state_q, state_d;
    logic [NUM_CH-1:0] sel_q, sel_d;
    logic              cas_q, cas_d;
    logic              take;
    logic              finish;

    // Service end: cascade ends on request drop, normal on the done pulse.
    assign finish = cas_q ? ~|(sel_q & req_i) : xfer_done_i;

    // Next-state and selection logic.
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        cas_d   = cas_q;
        take    = 1'b0;
        case (state_q)
            ARB_IDLE: begin
                if (elig_any_i) state_d = ARB_WAIT;
            end
            ARB_WAIT: begin
                if (!elig_any_i)     state_d = ARB_IDLE;
                else if (hold_ack_i) take    = 1'b1;
            end
            ARB_OWN: begin
                if (!hold_ack_i) begin
                    state_d = ARB_IDLE;
                    sel_d   = '0;
                    cas_d   = 1'b0;
                end else if (finish) begin
                    if (elig_any_i) begin
                        take = 1'b1;
                    end else begin
                        state_d = ARB_IDLE;
                        sel_d   = '0;
                        cas_d   = 1'b0;
                    end
                end
            end
            default: begin
                state_d = ARB_IDLE;
                sel_d   = '0;
                cas_d   = 1'b0;
            end
        endcase
        if (take) begin
            state_d = ARB_OWN;
            sel_d   = pick_i;
            cas_d   = |(pick_i & cascade_i);
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            sel_q   <= '0;
            cas_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            cas_q   <= cas_d;
        end
    end

    // Output decode: hold whenever not idle, grant or acknowledge by mode.
    always_comb begin
        hold_req_o = (state_q != ARB_IDLE);
        grant_o    = (state_q == ARB_OWN && !cas_q) ? sel_q : '0;
        cas_ack_o  = (state_q == ARB_OWN &&  cas_q) ? sel_q : '0;
    end

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_o, cas_ack_o})); // R4
    AST_HOLD_WHILE_SERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (|{grant_o, cas_ack_o}) |-> hold_req_o); // R2
    AST_NO_GRANT_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|{grant_o, cas_ack_o}) |-> $past(hold_ack_i)); // R2
    AST_PASS_ON_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && xfer_done_i && hold_ack_i && elig_any_i) |=> hold_req_o); // R5
    AST_RELEASE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o && xfer_done_i && !elig_any_i) |=> !hold_req_o); // R6
    AST_CASCADE_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cas_ack_o & req_i) && hold_ack_i) |=> (cas_ack_o == $past(cas_ack_o))); // R8
    AST_ACK_LOSS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|{grant_o, cas_ack_o} && !hold_ack_i) |=> !(|{grant_o, cas_ack_o})); // R9
endmodule

// File: rtl/dma_bus_arbiter.sv
// Module: top of the DMA bus-ownership arbiter. Qualifies requests with masks,
// picks by fixed priority (channel 0 highest) and sequences bus ownership.
// Assumes: all inputs synchronous to clk; reset synchronous and active low.
module dma_bus_arbiter #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] mask_i,
    input  logic [NUM_CH-1:0] cascade_i,
    input  logic              hold_ack_i,
    input  logic              xfer_done_i,
    output logic              hold_req_o,
    output logic [NUM_CH-1:0] grant_o,
    output logic [NUM_CH-1:0] cas_ack_o
);
    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] pick;
    logic              elig_any;

    dma_elig_mask #(.NUM_CH(NUM_CH)) i_elig (
        .req_i  (req_i),
        .mask_i (mask_i),
        .elig_o (elig)
    );

    dma_prio_pick #(.NUM_CH(NUM_CH)) i_prio (
        .elig_i (elig),
        .pick_o (pick),
        .any_o  (elig_any)
    );

    dma_arb_fsm #(.NUM_CH(NUM_CH)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_ack_i  (hold_ack_i),
        .xfer_done_i (xfer_done_i),
        .req_i       (req_i),
        .cascade_i   (cascade_i),
        .pick_i      (pick),
        .elig_any_i  (elig_any),
        .hold_req_o  (hold_req_o),
        .grant_o     (grant_o),
        .cas_ack_o   (cas_ack_o)
    );

    AST_MASKED_NEVER_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|{grant_o, cas_ack_o}) |-> ~|({grant_o, cas_ack_o} & {$past(mask_i), $past(mask_i)})); // R1
endmodule

// File: tb/test_dma_bus_arbiter.sv
// Bench: directed scenarios for the DMA bus-ownership arbiter, one task each.
module test_dma_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req, mask, cascade;
    logic       hold_ack, done;
    logic       hold_req;
    logic [3:0] grant, cas_ack;

    // Chain: a slave arbiter hangs off master channel 1.
    logic [3:0] s_req, s_grant, s_cas;
    logic       s_done, s_hold, m2_hack;
    logic [3:0] m2_grant, m2_cas;
    logic       m2_hold;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    dma_bus_arbiter i_dma_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .cascade_i(cascade),
        .hold_ack_i(hold_ack), .xfer_done_i(done),
        .hold_req_o(hold_req), .grant_o(grant), .cas_ack_o(cas_ack)
    );

    dma_bus_arbiter i_chain_master (
        .clk(clk), .rst_n(rst_n), .req_i({2'b00, s_hold, 1'b0}), .mask_i(4'b0000),
        .cascade_i(4'b0010), .hold_ack_i(m2_hack), .xfer_done_i(1'b0),
        .hold_req_o(m2_hold), .grant_o(m2_grant), .cas_ack_o(m2_cas)
    );

    dma_bus_arbiter i_chain_slave (
        .clk(clk), .rst_n(rst_n), .req_i(s_req), .mask_i(4'b0000),
        .cascade_i(4'b0000), .hold_ack_i(m2_cas[1]), .xfer_done_i(s_done),
        .hold_req_o(s_hold), .grant_o(s_grant), .cas_ack_o(s_cas)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] outs();
        return {hold_req, grant, cas_ack};
    endfunction

    task automatic idle_inputs();
        req = 4'b0; mask = 4'b0; cascade = 4'b0; hold_ack = 1'b0; done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle_inputs(); req = 4'b1111; hold_ack = 1'b1;
        s_req = 4'b0; s_done = 1'b0; m2_hack = 1'b0;
        repeat (3) tick();
        check("R11 during reset", outs(), 9'b0);
        req = 4'b0; hold_ack = 1'b0;
        rst_n = 1'b1;
        tick();
        check("R11 after reset", outs(), 9'b0);
    endtask

    task automatic t_masked();
        mask = 4'b0001; req = 4'b0001;
        repeat (3) tick();
        check("R1 masked no hold", outs(), 9'b0);
        req = 4'b0011;
        tick();
        check("R2 hold raised", outs(), {1'b1, 8'b0});
        hold_ack = 1'b1;
        tick();
        check("R1 masked skipped", outs(), {1'b1, 4'b0010, 4'b0});
        req = 4'b0001; done = 1'b1;
        tick();
        check("R6 release", outs(), 9'b0);
        idle_inputs();
        tick();
    endtask

    task automatic t_priority();
        req = 4'b1110;
        tick();
        check("R2 no grant before ack", outs(), {1'b1, 8'b0});
        tick();
        check("R2 still waiting", outs(), {1'b1, 8'b0});
        hold_ack = 1'b1;
        tick();
        check("R3 ch1 wins", outs(), {1'b1, 4'b0010, 4'b0});
        req = 4'b1100; done = 1'b1;
        tick();
        check("R5 pass to ch2", outs(), {1'b1, 4'b0100, 4'b0});
        req = 4'b1000;
        tick();
        check("R5 pass to ch3", outs(), {1'b1, 4'b1000, 4'b0});
        req = 4'b0000;
        tick();
        check("R6 hold dropped", outs(), 9'b0);
        idle_inputs();
        tick();
    endtask

    task automatic t_cascade();
        cascade = 4'b0100; req = 4'b0100;
        tick();
        hold_ack = 1'b1;
        tick();
        check("R7 cascade ack only", outs(), {1'b1, 4'b0, 4'b0100});
        done = 1'b1;
        tick();
        check("R7 done ignored", outs(), {1'b1, 4'b0, 4'b0100});
        done = 1'b0;
        repeat (2) tick();
        check("R8 cascade persists", outs(), {1'b1, 4'b0, 4'b0100});
        req = 4'b0000;
        tick();
        check("R8 cascade end release", outs(), 9'b0);
        hold_ack = 1'b0;
        cascade = 4'b0001; req = 4'b0001;
        tick();
        hold_ack = 1'b1;
        tick();
        check("R7 cascade ch0", outs(), {1'b1, 4'b0, 4'b0001});
        req = 4'b1000;
        tick();
        check("R8 pass after cascade", outs(), {1'b1, 4'b1000, 4'b0});
        idle_inputs();
        tick();
    endtask

    task automatic t_ack_loss();
        req = 4'b0010;
        tick();
        hold_ack = 1'b1;
        tick();
        check("R9 served", outs(), {1'b1, 4'b0010, 4'b0});
        hold_ack = 1'b0;
        tick();
        check("R9 grant removed", outs(), 9'b0);
        tick();
        check("R9 re-request", outs(), {1'b1, 8'b0});
        req = 4'b0;
        tick();
        check("R10 withdraw in wait", outs(), 9'b0);
        req = 4'b0100;
        tick();
        check("R10 hold up", outs(), {1'b1, 8'b0});
        req = 4'b0000;
        tick();
        hold_ack = 1'b1;
        tick();
        check("R10 no grant after withdraw", outs(), 9'b0);
        idle_inputs();
        tick();
    endtask

    task automatic t_chain();
        s_req = 4'b0100;
        for (int i = 0; i < 10 && !m2_hold; i++) tick();
        check("R12 master hold from slave", {8'b0, m2_hold}, 9'd1);
        m2_hack = 1'b1;
        for (int i = 0; i < 10 && s_grant == 4'b0; i++) tick();
        check("R12 slave grant", {1'b0, s_grant, m2_cas}, {1'b0, 4'b0100, 4'b0010});
        check("R12 master grant empty", {5'b0, m2_grant}, 9'b0);
        s_req = 4'b0; s_done = 1'b1;
        tick();
        s_done = 1'b0;
        tick();
        check("R12 chain released", {m2_hold, m2_cas, s_hold, 3'b0}, 9'b0);
        m2_hack = 1'b0;
        tick();
    endtask

    initial begin
        t_reset();
        t_masked();
        t_priority();
        t_cascade();
        t_ack_loss();
        t_chain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule